// File: doc/BRIEF.md
# Reset Cause Capture Unit

This block gathers the reset requests of a small chip into one system reset request and records in a status field which request was the root cause of the most recent reset. It watches nine request inputs: power-on, the reset pin, a supply-input brown-out, a regulated-rail brown-out, a core-voltage loss, a clock loss, a power-management timeout, a warm reset request and a software reset bit. The three voltage-loss requests and the clock-loss request each pass through an enable bit before they can cause a reset. Analog detectors and pad logic sit outside; their outputs arrive here as plain bits.

Capture works in three phases. While armed, the first cycle in which any qualified request is present latches the code of the highest-priority request. The unit then waits until every request has gone away. It then spends exactly one clock cycle copying the latched code into the visible status field. A request that arrives during that copy cycle is captured as power-on, whatever its real source. The unit also keeps two wake-from-shutdown flags. Both are forced clear while the pad sleep-disable control is set.

Top module: `rst_cause_capture`

## Requirements
- R1: After reset, `cause_o` is 0, `sys_rst_o` is 0, both wake flags are 0, `pad_sleep_dis_o` is 0, and `loss_en_o` (bit 3 clock loss, bit 2 core, bit 1 rail, bit 0 supply) is 4'b0111.
- R2: Cause codes are 0 power-on, 1 reset pin, 2 supply brown-out, 4 rail brown-out or core-voltage loss, 5 clock loss, 6 software reset or power-management timeout, 7 warm reset. Code 3 never appears.
- R3: `sys_rst_o` is high in the cycle after any qualified request is present, and low in the cycle after none is present.
- R4: When several requests are present in the capture cycle, the one reported is the first in this order: power-on, pin, supply brown-out, rail brown-out, core loss, clock loss, software, timeout, warm.
- R5: Once a cause is latched, requests that arrive later do not replace it. `cause_o` does not change while any request remains present. It updates only after all requests have been released.
- R6: In the single copy cycle after release, any new request is captured as code 0. That code is reported after that request is released. The cause copied in that cycle is still shown first.
- R7: A control write with `ctl_wdata_i` bit 0 set raises a software reset reported as code 6. A write with bit 0 clear raises no reset.
- R8: Control write bits 4..1 load the clock-loss, core, rail and supply enables. A clock-loss request causes no reset while its enable is 0, and neither does a supply brown-out while its enable is 0.
- R9: `wake_sd_o` and `wake_io_o` set on their event inputs and hold. Both are clear in every cycle after one in which `pad_sleep_dis_o` is 1, and events are ignored while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 2 MHz in the target system |
| rst_n | input | 1 | Asynchronous active-low reset of this block |
| por_i | input | 1 | Power-on request |
| pin_i | input | 1 | Reset pin request |
| bod_supply_i | input | 1 | Supply-input brown-out |
| bod_rail_i | input | 1 | Regulated-rail brown-out |
| core_loss_i | input | 1 | Core-voltage loss |
| clk_loss_i | input | 1 | Clock-loss detect |
| pm_timeout_i | input | 1 | Power-management timeout |
| warm_req_i | input | 1 | Warm reset request |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 5 | Control write data: bit 0 software reset, bits 4..1 enables |
| pad_we_i | input | 1 | Pad sleep-disable write strobe |
| pad_wdata_i | input | 1 | Pad sleep-disable write value |
| wake_sd_evt_i | input | 1 | Wake-from-shutdown event |
| wake_io_evt_i | input | 1 | I/O wake-from-shutdown event |
| sys_rst_o | output | 1 | Combined system reset request |
| cause_o | output | 3 | Reported root cause code |
| loss_en_o | output | 4 | Enables readback: clock, core, rail, supply |
| pad_sleep_dis_o | output | 1 | Pad sleep-disable control |
| wake_sd_o | output | 1 | Wake-from-shutdown flag |
| wake_io_o | output | 1 | I/O wake flag |

## Verification
Each request source is pulsed on its own first. This separates every code and shows that core loss and rail brown-out share code 4. Mixed patterns with several sources in the same cycle then check the priority order. Patterns that hold one source while another arrives and the first departs show that only the first cause is kept and that the status waits for full release. A request placed exactly in the copy cycle shows the forced power-on code, which separates a one-cycle copy window from an immediate re-arm.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int CODE_W = 3;
  localparam int NSRC   = 9;
  localparam int EN_W   = 4;
  localparam int CTL_W  = EN_W + 1;

  // source index; lower index wins
  localparam int S_POR  = 0;
  localparam int S_PIN  = 1;
  localparam int S_SUP  = 2;
  localparam int S_RAIL = 3;
  localparam int S_CORE = 4;
  localparam int S_CLK  = 5;
  localparam int S_SW   = 6;
  localparam int S_TMO  = 7;
  localparam int S_WARM = 8;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_HELD  = 2'd1,
    ST_COPY  = 2'd2
  } cap_state_e;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    logic [CODE_W-1:0] c;
    case (idx)
      S_POR:   c = 3'd0;
      S_PIN:   c = 3'd1;
      S_SUP:   c = 3'd2;
      S_RAIL:  c = 3'd4;
      S_CORE:  c = 3'd4;
      S_CLK:   c = 3'd5;
      S_SW:    c = 3'd6;
      S_TMO:   c = 3'd6;
      default: c = 3'd7;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/rcc_ctl_regs.sv
module rcc_ctl_regs
  import rcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             pad_we_i,
  input  logic             pad_wdata_i,
  output logic [EN_W-1:0]  en_o,
  output logic             sw_req_o,
  output logic             pad_dis_o
);
  localparam logic [EN_W-1:0] EN_RST = 4'b0111;

  logic [EN_W-1:0] en_q, en_d;
  logic            sw_q, sw_d;
  logic            pad_q, pad_d;
  logic            en_ce, pad_ce;

  assign en_ce  = ctl_we_i;
  assign pad_ce = pad_we_i;

  always_comb begin
    en_d  = ctl_wdata_i[CTL_W-1:1];
    sw_d  = ctl_we_i & ctl_wdata_i[0];
    pad_d = pad_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= EN_RST;
      sw_q  <= 1'b0;
      pad_q <= 1'b0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      sw_q <= sw_d;
      if (pad_ce) pad_q <= pad_d;
    end
  end

  assign en_o      = en_q;
  assign sw_req_o  = sw_q;
  assign pad_dis_o = pad_q;
endmodule

// File: rtl/rcc_src_qual.sv
module rcc_src_qual
  import rcc_pkg::*;
(
  input  logic [NSRC-1:0]   raw_i,
  input  logic [EN_W-1:0]   en_i,
  output logic [NSRC-1:0]   qual_o,
  output logic              any_o,
  output logic [CODE_W-1:0] root_o
);
  logic [NSRC-1:0] mask;

  // enable bit order: 0 supply, 1 rail, 2 core, 3 clock loss
  for (genvar g = 0; g < NSRC; g++) begin : g_mask
    if (g == S_SUP) begin : g_sup
      assign mask[g] = en_i[0];
    end else if (g == S_RAIL) begin : g_rail
      assign mask[g] = en_i[1];
    end else if (g == S_CORE) begin : g_core
      assign mask[g] = en_i[2];
    end else if (g == S_CLK) begin : g_clk
      assign mask[g] = en_i[3];
    end else begin : g_on
      assign mask[g] = 1'b1;
    end
  end

  assign qual_o = raw_i & mask;
  assign any_o  = |qual_o;

  always_comb begin
    root_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual_o[i]) root_o = src_code(i);
    end
  end
endmodule

// File: rtl/rcc_capture_fsm.sv
module rcc_capture_fsm
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [CODE_W-1:0] root_i,
  output logic              sys_rst_o,
  output logic [CODE_W-1:0] cause_o,
  output cap_state_e        state_o
);
  localparam logic [CODE_W-1:0] CODE_POR = '0;

  cap_state_e        st_q, st_d;
  logic [CODE_W-1:0] cap_q, cap_d;
  logic [CODE_W-1:0] stat_q, stat_d;
  logic              rst_q;

  always_comb begin
    st_d   = st_q;
    cap_d  = cap_q;
    stat_d = stat_q;
    case (st_q)
      ST_ARMED: begin
        if (any_i) begin
          cap_d = root_i;
          st_d  = ST_HELD;
        end
      end
      ST_HELD: begin
        if (!any_i) st_d = ST_COPY;
      end
      ST_COPY: begin
        stat_d = cap_q;
        if (any_i) begin
          cap_d = CODE_POR;
          st_d  = ST_HELD;
        end else begin
          st_d = ST_ARMED;
        end
      end
      default: st_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ARMED;
      cap_q  <= CODE_POR;
      stat_q <= CODE_POR;
      rst_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cap_q  <= cap_d;
      stat_q <= stat_d;
      rst_q  <= any_i;
    end
  end

  assign sys_rst_o = rst_q;
  assign cause_o   = stat_q;
  assign state_o   = st_q;
endmodule

// File: rtl/rcc_wake_flags.sv
module rcc_wake_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_dis_i,
  input  logic sd_evt_i,
  input  logic io_evt_i,
  output logic sd_o,
  output logic io_o
);
  logic sd_q, sd_d, io_q, io_d;

  always_comb begin
    sd_d = pad_dis_i ? 1'b0 : (sd_q | sd_evt_i);
    io_d = pad_dis_i ? 1'b0 : (io_q | io_evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q <= 1'b0;
      io_q <= 1'b0;
    end else begin
      sd_q <= sd_d;
      io_q <= io_d;
    end
  end

  assign sd_o = sd_q;
  assign io_o = io_q;
endmodule

// File: rtl/rst_cause_capture.sv
module rst_cause_capture
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              pin_i,
  input  logic              bod_supply_i,
  input  logic              bod_rail_i,
  input  logic              core_loss_i,
  input  logic              clk_loss_i,
  input  logic              pm_timeout_i,
  input  logic              warm_req_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              pad_we_i,
  input  logic              pad_wdata_i,
  input  logic              wake_sd_evt_i,
  input  logic              wake_io_evt_i,
  output logic              sys_rst_o,
  output logic [CODE_W-1:0] cause_o,
  output logic [EN_W-1:0]   loss_en_o,
  output logic              pad_sleep_dis_o,
  output logic              wake_sd_o,
  output logic              wake_io_o
);
  logic [EN_W-1:0]   en;
  logic              sw_req;
  logic              pad_dis;
  logic [NSRC-1:0]   raw;
  logic [NSRC-1:0]   qual;
  logic              src_any;
  logic [CODE_W-1:0] root;
  cap_state_e        cap_state;

  rcc_ctl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .pad_we_i    (pad_we_i),
    .pad_wdata_i (pad_wdata_i),
    .en_o        (en),
    .sw_req_o    (sw_req),
    .pad_dis_o   (pad_dis)
  );

  always_comb begin
    raw         = '0;
    raw[S_POR]  = por_i;
    raw[S_PIN]  = pin_i;
    raw[S_SUP]  = bod_supply_i;
    raw[S_RAIL] = bod_rail_i;
    raw[S_CORE] = core_loss_i;
    raw[S_CLK]  = clk_loss_i;
    raw[S_SW]   = sw_req;
    raw[S_TMO]  = pm_timeout_i;
    raw[S_WARM] = warm_req_i;
  end

  rcc_src_qual u_qual (
    .raw_i  (raw),
    .en_i   (en),
    .qual_o (qual),
    .any_o  (src_any),
    .root_o (root)
  );

  rcc_capture_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_i     (src_any),
    .root_i    (root),
    .sys_rst_o (sys_rst_o),
    .cause_o   (cause_o),
    .state_o   (cap_state)
  );

  rcc_wake_flags u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_dis_i (pad_dis),
    .sd_evt_i  (wake_sd_evt_i),
    .io_evt_i  (wake_io_evt_i),
    .sd_o      (wake_sd_o),
    .io_o      (wake_io_o)
  );

  assign loss_en_o       = {en[3], en[2], en[1], en[0]};
  assign pad_sleep_dis_o = pad_dis;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
  import rcc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              src_any,
  input logic              ctl_we_i,
  input logic [CTL_W-1:0]  ctl_wdata_i,
  input logic              sys_rst_o,
  input logic [CODE_W-1:0] cause_o,
  input logic              pad_sleep_dis_o,
  input logic              wake_sd_o,
  input logic              wake_io_o
);
  p_rst_follows_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o == $past(src_any));

  p_no_code3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cause_o != 3'd3);

  p_cause_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sys_rst_o) |-> $stable(cause_o));

  p_sw_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we_i && ctl_wdata_i[0]) |=> ##1 sys_rst_o);

  p_wake_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pad_sleep_dis_o |=> (!wake_sd_o && !wake_io_o));
endmodule

bind rst_cause_capture rcc_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .src_any         (src_any),
  .ctl_we_i        (ctl_we_i),
  .ctl_wdata_i     (ctl_wdata_i),
  .sys_rst_o       (sys_rst_o),
  .cause_o         (cause_o),
  .pad_sleep_dis_o (pad_sleep_dis_o),
  .wake_sd_o       (wake_sd_o),
  .wake_io_o       (wake_io_o)
);

// File: tb/rst_cause_capture_tb.sv
module rst_cause_capture_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_i = 0, pin_i = 0, bod_supply_i = 0, bod_rail_i = 0;
  logic       core_loss_i = 0, clk_loss_i = 0, pm_timeout_i = 0, warm_req_i = 0;
  logic       ctl_we_i = 0;
  logic [4:0] ctl_wdata_i = '0;
  logic       pad_we_i = 0, pad_wdata_i = 0;
  logic       wake_sd_evt_i = 0, wake_io_evt_i = 0;
  logic       sys_rst_o;
  logic [2:0] cause_o;
  logic [3:0] loss_en_o;
  logic       pad_sleep_dis_o, wake_sd_o, wake_io_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_cause_capture dut_i (.*);

  // vector: {warm,tmo,clk,core,rail,supply,pin,por} , expected code
  localparam logic [10:0] VEC [0:10] = '{
    {8'b0000_0010, 3'd1},
    {8'b0000_0100, 3'd2},
    {8'b0000_1000, 3'd4},
    {8'b0001_0000, 3'd4},
    {8'b0010_0000, 3'd4},
    {8'b0100_0000, 3'd6},
    {8'b1000_0000, 3'd7},
    {8'b0000_0001, 3'd0},
    {8'b1000_0110, 3'd1},
    {8'b0110_1000, 3'd4},
    {8'b1100_0000, 3'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_src(input logic [7:0] v);
    {warm_req_i, pm_timeout_i, clk_loss_i, core_loss_i,
     bod_rail_i, bod_supply_i, pin_i, por_i} = v;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); set_src(v);
    @(negedge clk); set_src('0);
    repeat (3) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [4:0] d);
    @(negedge clk); ctl_we_i = 1; ctl_wdata_i = d;
    @(negedge clk); ctl_we_i = 0; ctl_wdata_i = '0;
  endtask

  task automatic pad_write(input logic d);
    @(negedge clk); pad_we_i = 1; pad_wdata_i = d;
    @(negedge clk); pad_we_i = 0;
  endtask

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cause", cause_o, 3'd0);
    chk("R1 sys_rst", sys_rst_o, 1'b0);
    chk("R1 loss_en", loss_en_o, 4'b0111);
    chk("R1 wake", {pad_sleep_dis_o, wake_sd_o, wake_io_o}, 3'b000);

    // R2 / R4 / R8 table of single and combined sources
    for (int i = 0; i < 11; i++) begin
      pulse(VEC[i][10:3]);
      chk($sformatf("R2 R4 R8 vec%0d", i), cause_o, VEC[i][2:0]);
    end

    // R3 sys_rst follows a held source
    @(negedge clk); pin_i = 1;
    @(negedge clk);
    chk("R3 sys_rst high", sys_rst_o, 1'b1);
    pin_i = 0;
    @(negedge clk);
    chk("R3 sys_rst low", sys_rst_o, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 pin", cause_o, 3'd1);

    // R7 write of 0 to software bit has no effect
    seen = 0;
    @(negedge clk); ctl_we_i = 1; ctl_wdata_i = 5'b01110;
    @(negedge clk); ctl_we_i = 0; ctl_wdata_i = '0;
    repeat (4) begin
      if (sys_rst_o) seen = 1;
      @(negedge clk);
    end
    chk("R7 zero write no reset", seen, 1'b0);
    chk("R7 zero write cause", cause_o, 3'd1);

    // R7 software reset
    ctl_write(5'b01111);
    repeat (4) @(negedge clk);
    chk("R7 sw cause", cause_o, 3'd6);

    // R8 clock-loss enable
    ctl_write(5'b11110);
    chk("R8 en readback", loss_en_o, 4'b1111);
    pulse(8'b0010_0000);
    chk("R8 clk loss", cause_o, 3'd5);

    // R8 supply enable off
    ctl_write(5'b11100);
    chk("R8 en readback2", loss_en_o, 4'b1110);
    @(negedge clk); bod_supply_i = 1;
    @(negedge clk);
    chk("R8 supply masked sys_rst", sys_rst_o, 1'b0);
    bod_supply_i = 0;
    repeat (3) @(negedge clk);
    chk("R8 supply masked cause", cause_o, 3'd5);

    // R5 first cause kept, no re-arm until all released
    @(negedge clk); pin_i = 1;
    @(negedge clk); bod_rail_i = 1;
    @(negedge clk); pin_i = 0;
    repeat (3) @(negedge clk);
    chk("R5 held cause", cause_o, 3'd5);
    chk("R5 held sys_rst", sys_rst_o, 1'b1);
    bod_rail_i = 0;
    repeat (4) @(negedge clk);
    chk("R5 first cause", cause_o, 3'd1);

    // R6 request in copy cycle reports power-on
    @(negedge clk); pm_timeout_i = 1;
    @(negedge clk); pm_timeout_i = 0;
    @(negedge clk); warm_req_i = 1;
    @(negedge clk);
    chk("R6 copied cause", cause_o, 3'd6);
    warm_req_i = 0;
    repeat (3) @(negedge clk);
    chk("R6 forced por", cause_o, 3'd0);

    // R9 wake flags
    @(negedge clk); wake_sd_evt_i = 1; wake_io_evt_i = 1;
    @(negedge clk); wake_sd_evt_i = 0; wake_io_evt_i = 0;
    @(negedge clk);
    chk("R9 flags set", {wake_sd_o, wake_io_o}, 2'b11);
    pad_write(1'b1);
    @(negedge clk);
    chk("R9 flags cleared", {wake_sd_o, wake_io_o}, 2'b00);
    wake_sd_evt_i = 1;
    @(negedge clk); wake_sd_evt_i = 0;
    @(negedge clk);
    chk("R9 event ignored", {wake_sd_o, wake_io_o}, 2'b00);
    pad_write(1'b0);
    wake_io_evt_i = 1;
    @(negedge clk); wake_io_evt_i = 0;
    @(negedge clk);
    chk("R9 io flag again", {wake_sd_o, wake_io_o}, 2'b01);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule